// File: doc/BRIEF.md
# Run-Length Pixel Stream Serializer

This block turns a stream of 16-bit command words into a 9-bit RGB pixel output. It runs at four engine clocks per pixel time. Every word carries one colour and a 7-bit control code. The code either holds that colour for one or more pixel times, or it parks the engine until the line or frame marker from an external sync generator goes active. Because long horizontal runs take a single word, the upstream frame source can send compressed scanlines.

Words arrive over a valid/ready handshake from a FIFO. A word is taken only on the last engine clock of a pixel time, and only when the current run is over. If no word is waiting at that moment, the engine shows black for one pixel time and sets a sticky underflow flag. It then tries again at the next pixel boundary.

After a marker releases a wait, the engine shows one black lead-in pixel time and then fetches the next word. The sync generator is expected to raise the line marker one pixel time before the first visible pixel, so this lead-in keeps the line aligned.

Top module: `pxrun_serializer`

## Requirements
- R1: A command word carries the colour in bits 8..0 and the control code in bits 15..9, and the colour appears unchanged on rgb_out.
- R2: While rst_n is low and right after it is released, rgb_out and underflow are 0 and cmd_ready is low. The first word is accepted at the fourth rising edge after release and is shown from that edge on.
- R3: Code 0 holds the colour for exactly one pixel time (4 clocks). Consecutive single-pixel words give back-to-back pixels with no gap.
- R4: Codes 1, 2, 3 and 4 hold the colour for 2, 4, 7 and 8 pixel times, which is 8, 16, 28 and 32 clocks.
- R5: Code 5 makes the engine wait until frame_mark is high. The colour bits of that word are ignored, rgb_out is 0 while waiting, and line_mark has no effect on the wait.
- R6: Code 6 makes the engine wait until line_mark is high. Its colour bits are ignored, rgb_out is 0 while waiting, and frame_mark has no effect on the wait.
- R7: A marker that is sampled high at rising edge L during a wait ends the wait. rgb_out is 0 for the next four clocks, the next word is accepted at edge L+4, and that word is shown from edge L+4.
- R8: cmd_ready is high for exactly one clock, the last clock of a pixel time in which a new word is due. It stays low during runs and waits.
- R9: If cmd_valid is low when a word is due, the engine shows black for one pixel time and sets underflow. underflow stays set until reset, and a word that arrives later is taken at the next pixel boundary.
- R10: Codes 7 through 127 act as a single-pixel hold.
- R11: rgb_out changes only at pixel boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock, four per pixel time |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_data | input | 16 | Command word: control code in bits 15..9, colour in bits 8..0 |
| cmd_valid | input | 1 | A command word is presented |
| cmd_ready | output | 1 | The word is accepted this clock |
| line_mark | input | 1 | Line start marker from the sync generator |
| frame_mark | input | 1 | Frame start marker from the sync generator |
| rgb_out | output | 9 | Pixel colour |
| underflow | output | 1 | Sticky flag: a word was due and none was available |

## Verification
The assertions assume that cmd_data is stable and meaningful whenever cmd_valid is high, and that the markers are plain levels sampled on the rising edge, with no relation to the pixel phase. The stimulus meets this by driving every input on the falling edge. The word source advances only on a clock where both cmd_valid and cmd_ready were high. Markers are raised only while the engine is waiting, except in the checks that show the wrong marker is ignored.

// File: rtl/pxrun_pkg.sv
package pxrun_pkg;

    // width of the pixel-count field produced by the decoder
    localparam int HOLD_W = 4;

    // control code values (bits 15..9 of a command word)
    localparam int unsigned OP_HOLD1    = 0;
    localparam int unsigned OP_HOLD2    = 1;
    localparam int unsigned OP_HOLD4    = 2;
    localparam int unsigned OP_HOLD7    = 3;
    localparam int unsigned OP_HOLD8    = 4;
    localparam int unsigned OP_WAIT_FRM = 5;
    localparam int unsigned OP_WAIT_LN  = 6;

    typedef enum logic [1:0] {
        ENG_RUN      = 2'd0,
        ENG_WAIT_FRM = 2'd1,
        ENG_WAIT_LN  = 2'd2
    } eng_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD     = 2'd0,
        ACT_WAIT_FRM = 2'd1,
        ACT_WAIT_LN  = 2'd2
    } act_e;

    typedef struct packed {
        act_e              act;
        logic [HOLD_W-1:0] pixels;   // run length in pixel times, >= 1
    } cmd_action_t;

endpackage

// File: rtl/pxrun_code_decode.sv
module pxrun_code_decode
    import pxrun_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input  logic [CODE_W-1:0] code,
    output cmd_action_t       action
);

    always_comb begin
        action.act    = ACT_HOLD;
        action.pixels = HOLD_W'(1);
        case (code)
            CODE_W'(OP_HOLD1):    action.pixels = HOLD_W'(1);
            CODE_W'(OP_HOLD2):    action.pixels = HOLD_W'(2);
            CODE_W'(OP_HOLD4):    action.pixels = HOLD_W'(4);
            CODE_W'(OP_HOLD7):    action.pixels = HOLD_W'(7);
            CODE_W'(OP_HOLD8):    action.pixels = HOLD_W'(8);
            CODE_W'(OP_WAIT_FRM): action.act    = ACT_WAIT_FRM;
            CODE_W'(OP_WAIT_LN):  action.act    = ACT_WAIT_LN;
            default:              action.pixels = HOLD_W'(1); // unknown: one pixel
        endcase
    end

endmodule

// File: rtl/pxrun_sticky_flag.sv
module pxrun_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic flag
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R9: once raised, the flag holds until reset
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag);

endmodule

// File: rtl/pxrun_serializer.sv
module pxrun_serializer
    import pxrun_pkg::*;
#(
    parameter int RGB_W       = 9,
    parameter int CODE_W      = 7,
    parameter int CLK_PER_PIX = 4   // must be 2 or more
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [RGB_W+CODE_W-1:0] cmd_data,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic                    line_mark,
    input  logic                    frame_mark,
    output logic [RGB_W-1:0]        rgb_out,
    output logic                    underflow
);

    localparam int PH_W = $clog2(CLK_PER_PIX);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(CLK_PER_PIX - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [PH_W-1:0]   phase;  // engine clock within the pixel time
        logic [HOLD_W-1:0] left;   // pixel times still to hold after this one
        logic [RGB_W-1:0]  rgb;
    } eng_t;

    eng_t        eng_d, eng_q;
    cmd_action_t action;
    logic        word_due;
    logic        starve;

    pxrun_code_decode #(.CODE_W(CODE_W)) u_decode (
        .code   (cmd_data[RGB_W+CODE_W-1:RGB_W]),
        .action (action)
    );

    always_comb begin
        eng_d    = eng_q;
        word_due = (eng_q.st == ENG_RUN) && (eng_q.phase == LAST_PH) && (eng_q.left == '0);
        starve   = word_due && !cmd_valid;
        case (eng_q.st)
            ENG_RUN: begin
                if (eng_q.phase == LAST_PH) begin
                    eng_d.phase = '0;
                    if (eng_q.left != '0) begin
                        eng_d.left = eng_q.left - HOLD_W'(1);
                    end else if (!cmd_valid) begin
                        eng_d.rgb  = '0;
                        eng_d.left = '0;
                    end else begin
                        case (action.act)
                            ACT_WAIT_FRM: begin
                                eng_d.st  = ENG_WAIT_FRM;
                                eng_d.rgb = '0;
                            end
                            ACT_WAIT_LN: begin
                                eng_d.st  = ENG_WAIT_LN;
                                eng_d.rgb = '0;
                            end
                            default: begin
                                eng_d.rgb  = cmd_data[RGB_W-1:0];
                                eng_d.left = action.pixels - HOLD_W'(1);
                            end
                        endcase
                    end
                end else begin
                    eng_d.phase = eng_q.phase + PH_W'(1);
                end
            end
            ENG_WAIT_FRM: begin
                if (frame_mark) begin
                    eng_d.st    = ENG_RUN;
                    eng_d.phase = '0;
                    eng_d.left  = '0;
                    eng_d.rgb   = '0;
                end
            end
            ENG_WAIT_LN: begin
                if (line_mark) begin
                    eng_d.st    = ENG_RUN;
                    eng_d.phase = '0;
                    eng_d.left  = '0;
                    eng_d.rgb   = '0;
                end
            end
            default: begin
                eng_d.st    = ENG_RUN;
                eng_d.phase = '0;
                eng_d.left  = '0;
                eng_d.rgb   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q.st    <= ENG_RUN;
            eng_q.phase <= '0;
            eng_q.left  <= '0;
            eng_q.rgb   <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    pxrun_sticky_flag u_underflow (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (starve),
        .flag  (underflow)
    );

    assign cmd_ready = word_due;
    assign rgb_out   = eng_q.rgb;

    // R8: the handshake never stays open for two clocks in a row
    p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |=> !cmd_ready);

    // R5 / R6: black output whenever the engine is parked
    p_black_in_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st != ENG_RUN) |-> (rgb_out == '0));

    // R6: without the line marker, a line wait persists
    p_line_wait_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ENG_WAIT_LN && !line_mark) |=> (eng_q.st == ENG_WAIT_LN));

    // R5: without the frame marker, a frame wait persists
    p_frame_wait_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ENG_WAIT_FRM && !frame_mark) |=> (eng_q.st == ENG_WAIT_FRM));

    // R11: colour only moves at a pixel boundary
    p_pixel_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.phase != '0) |-> $stable(rgb_out));

    // R9: underflow rises only after an unanswered request
    p_underflow_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(cmd_ready && !cmd_valid));

endmodule

// File: tb/pxrun_serializer_tb.sv
module pxrun_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cmd_data;
    logic        cmd_valid;
    logic        cmd_ready;
    logic        line_mark;
    logic        frame_mark;
    logic [8:0]  rgb_out;
    logic        underflow;

    logic [15:0] words [32];
    int          nwords;
    bit          feed_en;
    int          idx;
    int          edge_now;
    int          n_chk;
    int          n_bad;

    always #4 clk = ~clk;

    pxrun_serializer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_data   (cmd_data),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .line_mark  (line_mark),
        .frame_mark (frame_mark),
        .rgb_out    (rgb_out),
        .underflow  (underflow)
    );

    // word source: advances only on an accepted handshake
    always_ff @(posedge clk) begin
        if (!rst_n)                      idx <= 0;
        else if (cmd_valid && cmd_ready) idx <= idx + 1;
    end
    assign cmd_valid = feed_en && (idx < nwords);
    assign cmd_data  = (idx < nwords) ? words[idx[4:0]] : 16'h0000;

    function automatic logic [15:0] mk(input int code, input int col);
        return {7'(code), 9'(col)};
    endfunction

    // run length in pixel times, from R3, R4, R10
    function automatic int run_len(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 7;
            4: return 8;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic goto(input int e);
        while (edge_now < e) begin
            @(negedge clk);
            edge_now++;
        end
    endtask

    task automatic do_reset();
        feed_en    = 1'b0;
        line_mark  = 1'b0;
        frame_mark = 1'b0;
        rst_n      = 1'b0;
        repeat (3) @(negedge clk);
        rst_n    = 1'b1;
        edge_now = 0;
    endtask

    task automatic t_reset_state();
        nwords = 0;
        do_reset();
        chk("R2 rgb after reset", 32'(rgb_out), 0);
        chk("R2 underflow after reset", 32'(underflow), 0);
        chk("R2 ready after reset", 32'(cmd_ready), 0);
        goto(3);
        chk("R8 ready on last clock of pixel", 32'(cmd_ready), 1);
        goto(4);
        chk("R9 underflow with empty source", 32'(underflow), 1);
        chk("R9 black on underflow", 32'(rgb_out), 0);
        chk("R8 ready closed after boundary", 32'(cmd_ready), 0);
    endtask

    task automatic t_runs();
        int codes [9] = '{0, 0, 1, 2, 3, 4, 9, 127, 0};
        int cols  [9] = '{'h101, 'h0AA, 'h155, 'h033, 'h1C7, 'h0F0, 'h11F, 'h1E1, 'h007};
        int e;
        nwords = 9;
        for (int i = 0; i < 9; i++) words[i] = mk(codes[i], cols[i]);
        do_reset();
        feed_en = 1'b1;
        e = 4;
        for (int i = 0; i < 9; i++) begin
            int n;
            string tag;
            n = run_len(codes[i]);
            tag = (codes[i] == 0) ? "R3" : ((codes[i] <= 4) ? "R4" : "R10");
            goto(e);
            chk({tag, " R1 first clock of run"}, 32'(rgb_out), 32'(cols[i]));
            if (n > 1) begin
                goto(e + 3);
                chk("R8 no ready inside run", 32'(cmd_ready), 0);
            end
            goto(e + 4 * n - 1);
            chk({tag, " last clock of run"}, 32'(rgb_out), 32'(cols[i]));
            e = e + 4 * n;
        end
        goto(e);
        chk("R9 black when source empty", 32'(rgb_out), 0);
        chk("R9 underflow raised", 32'(underflow), 1);
        words[9] = mk(0, 'h1AB);
        nwords   = 10;
        goto(e + 4);
        chk("R9 late word at next boundary", 32'(rgb_out), 32'h1AB);
        chk("R9 underflow sticky", 32'(underflow), 1);
        goto(e + 8);
        chk("R9 black again after late word", 32'(rgb_out), 0);
    endtask

    task automatic t_wait();
        nwords   = 4;
        words[0] = mk(6, 'h1FF);
        words[1] = mk(0, 'h123);
        words[2] = mk(5, 'h1FF);
        words[3] = mk(1, 'h0C3);
        do_reset();
        feed_en = 1'b1;
        goto(4);
        chk("R6 colour of wait word ignored", 32'(rgb_out), 0);
        chk("R2 underflow clear with data", 32'(underflow), 0);
        frame_mark = 1'b1;
        goto(12);
        chk("R6 frame marker ignored in line wait", 32'(rgb_out), 0);
        chk("R8 no ready while waiting", 32'(cmd_ready), 0);
        chk("R6 no word taken while waiting", 32'(idx), 1);
        frame_mark = 1'b0;
        line_mark  = 1'b1;
        goto(13);
        line_mark = 1'b0;
        chk("R7 black lead-in after marker", 32'(rgb_out), 0);
        goto(16);
        chk("R7 ready at end of lead-in", 32'(cmd_ready), 1);
        chk("R7 still black before first pixel", 32'(rgb_out), 0);
        goto(17);
        chk("R7 first pixel after line marker", 32'(rgb_out), 32'h123);
        goto(20);
        chk("R3 single pixel after wait", 32'(rgb_out), 32'h123);
        goto(21);
        chk("R5 black in frame wait", 32'(rgb_out), 0);
        line_mark = 1'b1;
        goto(29);
        chk("R5 line marker ignored in frame wait", 32'(rgb_out), 0);
        chk("R5 no word taken while waiting", 32'(idx), 3);
        line_mark  = 1'b0;
        frame_mark = 1'b1;
        goto(30);
        frame_mark = 1'b0;
        goto(33);
        chk("R7 black lead-in after frame marker", 32'(rgb_out), 0);
        goto(34);
        chk("R5 first pixel after frame marker", 32'(rgb_out), 32'h0C3);
        goto(41);
        chk("R4 two-pixel hold after frame wait", 32'(rgb_out), 32'h0C3);
        goto(42);
        chk("R9 underflow after last word", 32'(underflow), 1);
    endtask

    initial begin
        #(8 * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        n_chk      = 0;
        n_bad      = 0;
        nwords     = 0;
        feed_en    = 1'b0;
        edge_now   = 0;
        rst_n      = 1'b0;
        line_mark  = 1'b0;
        frame_mark = 1'b0;
        for (int i = 0; i < 32; i++) words[i] = 16'h0000;
        t_reset_state();
        t_runs();
        t_wait();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule